// File: doc/BRIEF.md
# N-to-1 AXI4 Write Merger

This block joins the write side of several AXI4 masters onto one AXI4 slave port. Each cycle in which no address is pending, a round-robin arbiter looks for a left port whose write address is valid and whose data-available flag is high. It locks onto that port, and the port's address is then offered on the right side until the slave accepts it. The right-side write ID is the left ID with the port number placed above it, so the slave can return responses without any lookup table.

Every lock pushes the port number into a small ordering queue. The queue head decides which left port drives the right W channel. When a beat with the last flag completes its handshake, the head advances, and the next burst can continue in the very next cycle. Write responses are steered back by the upper ID bits, and those bits are removed before the ID reaches the master. The data-available flag can simply be tied to the port's WVALID. With a single left port the block is plain wiring. It has no reset: its registers take initial values at power-up.

Top module: `axi_wr_merge`

## Requirements
- R1: At power-up, before any request, r_awvalid, r_wvalid and every bit of l_awready and l_wready are low, even while left W data is offered.
- R2: A left port can be locked only in a cycle where both its l_awvalid bit and its l_avail bit are high. A port with l_avail low is never granted.
- R3: Arbitration is round robin. After port p's address is accepted, the search for the next lock starts at port (p+1) mod N_PORTS, rising in index. The pointer starts at port 0.
- R4: r_awvalid rises on the clock edge after the lock cycle and stays high, with unchanged fields, until r_awready is seen. In the cycle after the handshake it is low, so at most one address is issued every second cycle.
- R5: r_awid is {port index, left AWID}, with the port index in the top ceil(log2(N_PORTS)) bits. Address, length, size and burst come from the locked port. l_awready is high only for the locked port, and only while r_awready is high.
- R6: Left ports drive W in the order they were locked. Only the queue-head port sees l_wready (equal to r_wready), and r_wvalid, r_wdata, r_wstrb and r_wlast come from that port. The head advances on a handshake with r_wlast high, and the next queued burst may transfer in the next cycle with no idle cycle.
- R7: At most ORDER_DEPTH bursts are locked but not yet finished on W. While that many are pending, no further address is locked.
- R8: When r_bvalid is high, l_bvalid is high only for the port given by the upper bits of r_bid. That port sees the low LID_W bits of r_bid as its l_bid and r_bresp as its l_bresp. r_bready equals that port's l_bready.
- R9: With N_PORTS = 1, every channel passes straight through in the same cycle, r_awid equals l_awid, and l_avail has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| l_awvalid | input | N_PORTS | Left address valid, one bit per port |
| l_awready | output | N_PORTS | Left address ready |
| l_awid | input | N_PORTS x LID_W | Left write ID |
| l_awaddr | input | N_PORTS x ADDR_W | Left address |
| l_awlen | input | N_PORTS x 8 | Left burst length minus one |
| l_awsize | input | N_PORTS x 3 | Left beat size |
| l_awburst | input | N_PORTS x 2 | Left burst type |
| l_avail | input | N_PORTS | Data-available flag that qualifies arbitration |
| l_wvalid | input | N_PORTS | Left write data valid |
| l_wready | output | N_PORTS | Left write data ready |
| l_wdata | input | N_PORTS x DATA_W | Left write data |
| l_wstrb | input | N_PORTS x DATA_W/8 | Left byte strobes |
| l_wlast | input | N_PORTS | Left last beat of burst |
| l_bvalid | output | N_PORTS | Left response valid |
| l_bready | input | N_PORTS | Left response ready |
| l_bid | output | N_PORTS x LID_W | Left response ID |
| l_bresp | output | N_PORTS x 2 | Left response code |
| r_awvalid | output | 1 | Right address valid |
| r_awready | input | 1 | Right address ready |
| r_awid | output | RID_W | Right write ID with port index on top |
| r_awaddr | output | ADDR_W | Right address |
| r_awlen | output | 8 | Right burst length minus one |
| r_awsize | output | 3 | Right beat size |
| r_awburst | output | 2 | Right burst type |
| r_wvalid | output | 1 | Right write data valid |
| r_wready | input | 1 | Right write data ready |
| r_wdata | output | DATA_W | Right write data |
| r_wstrb | output | DATA_W/8 | Right byte strobes |
| r_wlast | output | 1 | Right last beat |
| r_bvalid | input | 1 | Right response valid |
| r_bready | output | 1 | Right response ready |
| r_bid | input | RID_W | Right response ID |
| r_bresp | input | 2 | Right response code |

## Verification
The W and B paths and the whole single-port variant are combinational, so their outputs are sampled a short delay after the inputs change, within the same cycle. An address appears on the right one edge after the lock cycle and remains there for each cycle r_awready is held low. The edge that completes the handshake clears it, and the bench checks for a low r_awvalid right after that edge. The ordering queue is filled at the lock edge, so draining starts only after the address phase. The bench then checks one beat per cycle with no idle cycle between bursts, and checks that a cycle with r_wready low does not move the head.

// File: rtl/awm_pkg.sv
`timescale 1ns/1ps
package awm_pkg;

  // Bits needed to name a left port on the right side (zero when there is one port).
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 0;
  endfunction

  // Storage width for a port index; never zero so vectors stay legal.
  function automatic int idx_store_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Right-side ID width: left ID plus the appended port number.
  function automatic int right_id_bits(input int lid_w, input int n);
    return lid_w + idx_bits(n);
  endfunction

  // Round-robin successor of a granted port.
  function automatic int rr_after(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Circular pointer increment for a queue of any depth.
  function automatic int wrap_inc(input int v, input int depth);
    return (v + 1 >= depth) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/awm_arbiter.sv
`timescale 1ns/1ps
module awm_arbiter
  import awm_pkg::*;
#(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic [N-1:0]  req,
  input  logic          block,
  input  logic          aw_done,
  output logic          sel_valid,
  output logic [IW-1:0] sel_idx,
  output logic          lock,
  output logic [IW-1:0] lock_idx
);

  logic [IW-1:0] ptr_q   = '0;
  logic          valid_q = 1'b0;
  logic [IW-1:0] idx_q   = '0;

  function automatic logic [IW-1:0] rr_pick(input logic [N-1:0] r, input logic [IW-1:0] start);
    logic [IW-1:0] pick;
    logic          found;
    pick  = start;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = (int'(start) + k) % N;
      if (!found && r[c]) begin
        pick  = IW'(c);
        found = 1'b1;
      end
    end
    return pick;
  endfunction

  assign lock_idx  = rr_pick(req, ptr_q);
  assign lock      = !valid_q && !block && (|req);
  assign sel_valid = valid_q;
  assign sel_idx   = idx_q;

  always_ff @(posedge clk) begin
    if (lock) begin
      valid_q <= 1'b1;
      idx_q   <= lock_idx;
    end else if (aw_done) begin
      valid_q <= 1'b0;
      ptr_q   <= IW'(rr_after(int'(idx_q), N));
    end
  end

  // R4: the cycle after an accepted address carries no address
  a_r4_gap_after_issue: assert property (@(posedge clk) aw_done |=> !sel_valid);
  // R4: a pending address holds its port until accepted
  a_r4_hold_until_accept: assert property (@(posedge clk)
    sel_valid && !aw_done |=> sel_valid && $stable(sel_idx));
  // R7: a full ordering queue forbids new locks
  a_r7_block_stops_lock: assert property (@(posedge clk) block |-> !lock);

endmodule

// File: rtl/awm_order_fifo.sv
`timescale 1ns/1ps
module awm_order_fifo
  import awm_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IW    = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          push,
  input  logic [IW-1:0] push_idx,
  input  logic          pop,
  output logic          head_valid,
  output logic [IW-1:0] head_idx,
  output logic          full
);

  logic [IW-1:0] slots [DEPTH];
  logic [PW-1:0] wr_p = '0;
  logic [PW-1:0] rd_p = '0;
  logic [CW-1:0] used = '0;

  always_ff @(posedge clk) begin
    if (push) begin
      slots[wr_p] <= push_idx;
      wr_p        <= PW'(wrap_inc(int'(wr_p), DEPTH));
    end
    if (pop) begin
      rd_p <= PW'(wrap_inc(int'(rd_p), DEPTH));
    end
    case ({push, pop})
      2'b10:   used <= used + CW'(1);
      2'b01:   used <= used - CW'(1);
      default: used <= used;
    endcase
  end

  assign head_valid = (used != '0);
  assign head_idx   = slots[rd_p];
  assign full       = (used == CW'(DEPTH));

  // R7: the arbiter never pushes into a full queue
  a_r7_no_overflow: assert property (@(posedge clk) push |-> !full);
  // R6: a last beat only completes while a burst is queued
  a_r6_pop_has_head: assert property (@(posedge clk) pop |-> head_valid);

endmodule

// File: rtl/awm_resp_route.sv
`timescale 1ns/1ps
module awm_resp_route #(
  parameter int N     = 3,
  parameter int LID_W = 2,
  parameter int IW    = 2
) (
  input  logic                      r_bvalid,
  output logic                      r_bready,
  input  logic [LID_W+IW-1:0]       r_bid,
  input  logic [1:0]                r_bresp,
  output logic [N-1:0]              l_bvalid,
  input  logic [N-1:0]              l_bready,
  output logic [N-1:0][LID_W-1:0]   l_bid,
  output logic [N-1:0][1:0]         l_bresp
);

  logic [IW-1:0] dst;
  logic          dst_ok;

  assign dst      = r_bid[LID_W+IW-1:LID_W];
  assign dst_ok   = int'(dst) < N;
  assign r_bready = dst_ok && l_bready[dst];

  for (genvar i = 0; i < N; i++) begin : g_out
    assign l_bvalid[i] = r_bvalid && (dst == IW'(i));
    assign l_bid[i]    = r_bid[LID_W-1:0];
    assign l_bresp[i]  = r_bresp;
  end

endmodule

// File: rtl/axi_wr_merge.sv
`timescale 1ns/1ps
module axi_wr_merge
  import awm_pkg::*;
#(
  parameter int N_PORTS     = 3,
  parameter int LID_W       = 2,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int ORDER_DEPTH = 4,
  localparam int IDX_W      = idx_store_bits(N_PORTS),
  localparam int RID_W      = right_id_bits(LID_W, N_PORTS),
  localparam int STRB_W     = DATA_W / 8
) (
  input  logic                              clk,
  input  logic [N_PORTS-1:0]                l_awvalid,
  output logic [N_PORTS-1:0]                l_awready,
  input  logic [N_PORTS-1:0][LID_W-1:0]     l_awid,
  input  logic [N_PORTS-1:0][ADDR_W-1:0]    l_awaddr,
  input  logic [N_PORTS-1:0][7:0]           l_awlen,
  input  logic [N_PORTS-1:0][2:0]           l_awsize,
  input  logic [N_PORTS-1:0][1:0]           l_awburst,
  input  logic [N_PORTS-1:0]                l_avail,
  input  logic [N_PORTS-1:0]                l_wvalid,
  output logic [N_PORTS-1:0]                l_wready,
  input  logic [N_PORTS-1:0][DATA_W-1:0]    l_wdata,
  input  logic [N_PORTS-1:0][STRB_W-1:0]    l_wstrb,
  input  logic [N_PORTS-1:0]                l_wlast,
  output logic [N_PORTS-1:0]                l_bvalid,
  input  logic [N_PORTS-1:0]                l_bready,
  output logic [N_PORTS-1:0][LID_W-1:0]     l_bid,
  output logic [N_PORTS-1:0][1:0]           l_bresp,
  output logic                              r_awvalid,
  input  logic                              r_awready,
  output logic [RID_W-1:0]                  r_awid,
  output logic [ADDR_W-1:0]                 r_awaddr,
  output logic [7:0]                        r_awlen,
  output logic [2:0]                        r_awsize,
  output logic [1:0]                        r_awburst,
  output logic                              r_wvalid,
  input  logic                              r_wready,
  output logic [DATA_W-1:0]                 r_wdata,
  output logic [STRB_W-1:0]                 r_wstrb,
  output logic                              r_wlast,
  input  logic                              r_bvalid,
  output logic                              r_bready,
  input  logic [RID_W-1:0]                  r_bid,
  input  logic [1:0]                        r_bresp
);

  if (N_PORTS == 1) begin : g_pass
    // Single master: straight wiring, the data-available flag is not consulted.
    assign r_awvalid    = l_awvalid[0];
    assign l_awready[0] = r_awready;
    assign r_awid       = l_awid[0];
    assign r_awaddr     = l_awaddr[0];
    assign r_awlen      = l_awlen[0];
    assign r_awsize     = l_awsize[0];
    assign r_awburst    = l_awburst[0];
    assign r_wvalid     = l_wvalid[0];
    assign l_wready[0]  = r_wready;
    assign r_wdata      = l_wdata[0];
    assign r_wstrb      = l_wstrb[0];
    assign r_wlast      = l_wlast[0];
    assign l_bvalid[0]  = r_bvalid;
    assign r_bready     = l_bready[0];
    assign l_bid[0]     = r_bid;
    assign l_bresp[0]   = r_bresp;
  end else begin : g_merge
    logic [N_PORTS-1:0] req;
    logic               aw_done;
    logic               sel_valid;
    logic [IDX_W-1:0]   sel_idx;
    logic               lock;
    logic [IDX_W-1:0]   lock_idx;
    logic               head_valid;
    logic [IDX_W-1:0]   head_idx;
    logic               order_full;
    logic               w_pop;

    assign req     = l_awvalid & l_avail;
    assign aw_done = r_awvalid && r_awready;

    awm_arbiter #(
      .N  (N_PORTS),
      .IW (IDX_W)
    ) u_arb (
      .clk       (clk),
      .req       (req),
      .block     (order_full),
      .aw_done   (aw_done),
      .sel_valid (sel_valid),
      .sel_idx   (sel_idx),
      .lock      (lock),
      .lock_idx  (lock_idx)
    );

    // Address channel of the locked port.
    assign r_awvalid = sel_valid;
    assign r_awid    = {sel_idx, l_awid[sel_idx]};
    assign r_awaddr  = l_awaddr[sel_idx];
    assign r_awlen   = l_awlen[sel_idx];
    assign r_awsize  = l_awsize[sel_idx];
    assign r_awburst = l_awburst[sel_idx];

    awm_order_fifo #(
      .DEPTH (ORDER_DEPTH),
      .IW    (IDX_W)
    ) u_order (
      .clk        (clk),
      .push       (lock),
      .push_idx   (lock_idx),
      .pop        (w_pop),
      .head_valid (head_valid),
      .head_idx   (head_idx),
      .full       (order_full)
    );

    // Data channel of the queue-head port.
    assign r_wvalid = head_valid && l_wvalid[head_idx];
    assign r_wdata  = l_wdata[head_idx];
    assign r_wstrb  = l_wstrb[head_idx];
    assign r_wlast  = l_wlast[head_idx];
    assign w_pop    = r_wvalid && r_wready && r_wlast;

    for (genvar i = 0; i < N_PORTS; i++) begin : g_port
      assign l_awready[i] = sel_valid && (sel_idx == IDX_W'(i)) && r_awready;
      assign l_wready[i]  = head_valid && (head_idx == IDX_W'(i)) && r_wready;
    end

    awm_resp_route #(
      .N     (N_PORTS),
      .LID_W (LID_W),
      .IW    (IDX_W)
    ) u_resp (
      .r_bvalid (r_bvalid),
      .r_bready (r_bready),
      .r_bid    (r_bid),
      .r_bresp  (r_bresp),
      .l_bvalid (l_bvalid),
      .l_bready (l_bready),
      .l_bid    (l_bid),
      .l_bresp  (l_bresp)
    );

    // R2: a lock only picks a port that is both valid and data-available
    a_r2_lock_eligible: assert property (@(posedge clk)
      lock |-> (l_awvalid[lock_idx] && l_avail[lock_idx]));
    // R5: address ready reaches at most one master
    a_r5_awready_onehot: assert property (@(posedge clk) $onehot0(l_awready));
    // R6: data ready reaches at most one master
    a_r6_wready_onehot: assert property (@(posedge clk) $onehot0(l_wready));
    // R8: a response is shown to at most one master
    a_r8_bvalid_onehot: assert property (@(posedge clk) $onehot0(l_bvalid));
  end

endmodule

// File: tb/axi_wr_merge_tb.sv
`timescale 1ns/1ps
module axi_wr_merge_tb;
  localparam int N   = 3;
  localparam int LID = 2;
  localparam int AW  = 16;
  localparam int DW  = 16;
  localparam int SW  = 2;
  localparam int QD  = 4;
  localparam int RID = 4;
  localparam int BL  = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]          l_awvalid, l_awready, l_avail, l_wvalid, l_wready, l_wlast;
  logic [N-1:0]          l_bvalid, l_bready;
  logic [N-1:0][LID-1:0] l_awid, l_bid;
  logic [N-1:0][AW-1:0]  l_awaddr;
  logic [N-1:0][7:0]     l_awlen;
  logic [N-1:0][2:0]     l_awsize;
  logic [N-1:0][1:0]     l_awburst, l_bresp;
  logic [N-1:0][DW-1:0]  l_wdata;
  logic [N-1:0][SW-1:0]  l_wstrb;
  logic                  r_awvalid, r_awready, r_wvalid, r_wready, r_wlast, r_bvalid, r_bready;
  logic [RID-1:0]        r_awid, r_bid;
  logic [AW-1:0]         r_awaddr;
  logic [7:0]            r_awlen;
  logic [2:0]            r_awsize;
  logic [1:0]            r_awburst, r_bresp;
  logic [DW-1:0]         r_wdata;
  logic [SW-1:0]         r_wstrb;

  logic [0:0]          p_awvalid, p_awready, p_avail, p_wvalid, p_wready, p_wlast, p_bvalid, p_bready;
  logic [0:0][LID-1:0] p_awid, p_bid;
  logic [0:0][AW-1:0]  p_awaddr;
  logic [0:0][7:0]     p_awlen;
  logic [0:0][2:0]     p_awsize;
  logic [0:0][1:0]     p_awburst, p_bresp;
  logic [0:0][DW-1:0]  p_wdata;
  logic [0:0][SW-1:0]  p_wstrb;
  logic                pr_awvalid, pr_awready, pr_wvalid, pr_wready, pr_wlast, pr_bvalid, pr_bready;
  logic [LID-1:0]      pr_awid, pr_bid;
  logic [AW-1:0]       pr_awaddr;
  logic [7:0]          pr_awlen;
  logic [2:0]          pr_awsize;
  logic [1:0]          pr_awburst, pr_bresp;
  logic [DW-1:0]       pr_wdata;
  logic [SW-1:0]       pr_wstrb;

  axi_wr_merge #(.N_PORTS(N), .LID_W(LID), .ADDR_W(AW), .DATA_W(DW), .ORDER_DEPTH(QD)) u_dut (
    .clk(clk), .l_awvalid(l_awvalid), .l_awready(l_awready), .l_awid(l_awid), .l_awaddr(l_awaddr),
    .l_awlen(l_awlen), .l_awsize(l_awsize), .l_awburst(l_awburst), .l_avail(l_avail),
    .l_wvalid(l_wvalid), .l_wready(l_wready), .l_wdata(l_wdata), .l_wstrb(l_wstrb), .l_wlast(l_wlast),
    .l_bvalid(l_bvalid), .l_bready(l_bready), .l_bid(l_bid), .l_bresp(l_bresp),
    .r_awvalid(r_awvalid), .r_awready(r_awready), .r_awid(r_awid), .r_awaddr(r_awaddr),
    .r_awlen(r_awlen), .r_awsize(r_awsize), .r_awburst(r_awburst),
    .r_wvalid(r_wvalid), .r_wready(r_wready), .r_wdata(r_wdata), .r_wstrb(r_wstrb), .r_wlast(r_wlast),
    .r_bvalid(r_bvalid), .r_bready(r_bready), .r_bid(r_bid), .r_bresp(r_bresp));

  axi_wr_merge #(.N_PORTS(1), .LID_W(LID), .ADDR_W(AW), .DATA_W(DW), .ORDER_DEPTH(QD)) u_pass (
    .clk(clk), .l_awvalid(p_awvalid), .l_awready(p_awready), .l_awid(p_awid), .l_awaddr(p_awaddr),
    .l_awlen(p_awlen), .l_awsize(p_awsize), .l_awburst(p_awburst), .l_avail(p_avail),
    .l_wvalid(p_wvalid), .l_wready(p_wready), .l_wdata(p_wdata), .l_wstrb(p_wstrb), .l_wlast(p_wlast),
    .l_bvalid(p_bvalid), .l_bready(p_bready), .l_bid(p_bid), .l_bresp(p_bresp),
    .r_awvalid(pr_awvalid), .r_awready(pr_awready), .r_awid(pr_awid), .r_awaddr(pr_awaddr),
    .r_awlen(pr_awlen), .r_awsize(pr_awsize), .r_awburst(pr_awburst),
    .r_wvalid(pr_wvalid), .r_wready(pr_wready), .r_wdata(pr_wdata), .r_wstrb(pr_wstrb), .r_wlast(pr_wlast),
    .r_bvalid(pr_bvalid), .r_bready(pr_bready), .r_bid(pr_bid), .r_bresp(pr_bresp));

  int checks = 0;
  int errors = 0;
  int exp_ptr = 0;
  int exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, want);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int rr_expect(input logic [N-1:0] req);
    for (int k = 0; k < N; k++) begin
      int c;
      c = (exp_ptr + k) % N;
      if (req[c]) return c;
    end
    return -1;
  endfunction

  // One address from port p, optionally held off by the slave for 'stall' cycles.
  task automatic single_aw(input int p, input int id, input int stall);
    l_awvalid      = N'(1 << p);
    l_avail        = N'(1 << p);
    l_awid[p]      = LID'(id);
    l_awaddr[p]    = AW'(p * 256 + id * 4);
    l_awlen[p]     = 8'(BL - 1);
    l_awsize[p]    = 3'd1;
    l_awburst[p]   = 2'd1;
    r_awready      = (stall == 0);
    #1;
    chk(r_awvalid == 1'b0, "R4", "awvalid in lock cycle", r_awvalid, 0);
    step();
    #1;
    for (int s = 0; s < stall; s++) begin
      chk(r_awvalid == 1'b1, "R4", "awvalid held under stall", r_awvalid, 1);
      chk(r_awid == RID'({2'(p), 2'(id)}), "R4", "awid stable under stall", r_awid, {2'(p), 2'(id)});
      chk(l_awready == '0, "R5", "awready while slave stalls", l_awready, 0);
      step();
      #1;
    end
    r_awready = 1'b1;
    #1;
    chk(r_awvalid == 1'b1, "R4", "awvalid after lock", r_awvalid, 1);
    chk(r_awid == RID'({2'(p), 2'(id)}), "R5", "awid with port index", r_awid, {2'(p), 2'(id)});
    chk(r_awaddr == AW'(p * 256 + id * 4), "R5", "awaddr", r_awaddr, p * 256 + id * 4);
    chk(r_awlen == 8'(BL - 1), "R5", "awlen", r_awlen, BL - 1);
    chk(int'(l_awready) == (1 << p), "R5", "awready to locked port", l_awready, 1 << p);
    step();
    l_awvalid = '0;
    l_avail   = '0;
    #1;
    chk(r_awvalid == 1'b0, "R4", "gap after issue", r_awvalid, 0);
    exp_q.push_back(p);
    exp_ptr = (p + 1) % N;
  endtask

  // Drain every queued burst, all masters offering data, expecting queue order.
  task automatic drain(input bit stall_first);
    int beat[N];
    for (int i = 0; i < N; i++) beat[i] = 0;
    for (int i = 0; i < N; i++) begin
      l_wvalid[i] = 1'b1;
      l_wdata[i]  = {8'(i), 8'(0)};
      l_wstrb[i]  = SW'(i + 1);
      l_wlast[i]  = (BL == 1);
    end
    if (stall_first && exp_q.size() > 0) begin
      r_wready = 1'b0;
      #1;
      chk(r_wvalid == 1'b1, "R6", "wvalid with stalled slave", r_wvalid, 1);
      chk(l_wready == '0, "R6", "wready while slave stalls", l_wready, 0);
      step();
    end
    r_wready = 1'b1;
    while (exp_q.size() > 0) begin
      int h;
      h = exp_q[0];
      for (int i = 0; i < N; i++) begin
        l_wdata[i] = {8'(i), 8'(beat[i])};
        l_wlast[i] = (beat[i] == BL - 1);
      end
      #1;
      chk(r_wvalid == 1'b1, "R6", "wvalid every cycle", r_wvalid, 1);
      chk(r_wdata == {8'(h), 8'(beat[h])}, "R6", "wdata from head", r_wdata, {8'(h), 8'(beat[h])});
      chk(r_wstrb == SW'(h + 1), "R6", "wstrb from head", r_wstrb, h + 1);
      chk(r_wlast == (beat[h] == BL - 1), "R6", "wlast from head", r_wlast, beat[h] == BL - 1);
      chk(int'(l_wready) == (1 << h), "R6", "wready only head", l_wready, 1 << h);
      step();
      beat[h]++;
      if (beat[h] == BL) begin
        beat[h] = 0;
        void'(exp_q.pop_front());
      end
    end
    #1;
    chk(r_wvalid == 1'b0, "R6", "wvalid with empty queue", r_wvalid, 0);
    chk(l_wready == '0, "R6", "wready with empty queue", l_wready, 0);
    l_wvalid = '0;
    l_wlast  = '0;
  endtask

  // Hold a request pattern, count issued addresses and check their order.
  task automatic run_grants(input logic [N-1:0] vmask, input logic [N-1:0] amask,
                            input int cycles, input int want_count, input string req_tag);
    int count;
    bit gap;
    count = 0;
    gap   = 1'b0;
    r_awready = 1'b1;
    for (int i = 0; i < N; i++) begin
      l_awid[i]    = LID'(i);
      l_awaddr[i]  = AW'(16'h4000 + i);
      l_awlen[i]   = 8'(BL - 1);
      l_awsize[i]  = 3'd1;
      l_awburst[i] = 2'd1;
    end
    l_awvalid = vmask;
    l_avail   = amask;
    for (int c = 0; c < cycles; c++) begin
      #1;
      if (gap) begin
        chk(r_awvalid == 1'b0, "R4", "gap after issue", r_awvalid, 0);
        gap = 1'b0;
      end else if (r_awvalid) begin
        int e;
        e = rr_expect(vmask & amask);
        chk(int'(r_awid[RID-1:LID]) == e, "R3", "round-robin port", r_awid[RID-1:LID], e);
        chk(int'(r_awid[LID-1:0]) == e, "R5", "low id bits", r_awid[LID-1:0], e);
        if (e >= 0) begin
          exp_q.push_back(e);
          exp_ptr = (e + 1) % N;
        end
        count++;
        gap = 1'b1;
      end
      step();
    end
    l_awvalid = '0;
    l_avail   = '0;
    #1;
    chk(count == want_count, req_tag, "issued address count", count, want_count);
  endtask

  task automatic b_sweep();
    for (int p = 0; p < N; p++) begin
      for (int id = 0; id < 4; id++) begin
        for (int bp = 0; bp < 2; bp++) begin
          r_bvalid = 1'b1;
          r_bid    = RID'({2'(p), 2'(id)});
          r_bresp  = 2'(p + id);
          l_bready = (bp != 0) ? N'(1 << p) : ~N'(1 << p);
          #1;
          chk(int'(l_bvalid) == (1 << p), "R8", "bvalid to owner", l_bvalid, 1 << p);
          chk(int'(l_bid[p]) == id, "R8", "bid stripped", l_bid[p], id);
          chk(l_bresp[p] == 2'(p + id), "R8", "bresp", l_bresp[p], 2'(p + id));
          chk(int'(r_bready) == bp, "R8", "bready from owner", r_bready, bp);
          step();
        end
      end
    end
    r_bvalid = 1'b0;
    #1;
    chk(l_bvalid == '0, "R8", "bvalid idle", l_bvalid, 0);
  endtask

  task automatic pass_checks();
    p_avail     = 1'b0;
    p_awvalid   = 1'b1;
    p_awid[0]   = 2'h2;
    p_awaddr[0] = 16'h1234;
    pr_awready  = 1'b1;
    p_wvalid    = 1'b1;
    p_wdata[0]  = 16'hbeef;
    p_wlast     = 1'b1;
    pr_wready   = 1'b0;
    pr_bvalid   = 1'b1;
    pr_bid      = 2'h1;
    p_bready    = 1'b1;
    #1;
    chk(pr_awvalid == 1'b1, "R9", "awvalid ignores avail", pr_awvalid, 1);
    chk(pr_awid == 2'h2, "R9", "awid unchanged", pr_awid, 2);
    chk(pr_awaddr == 16'h1234, "R9", "awaddr", pr_awaddr, 16'h1234);
    chk(p_awready == 1'b1, "R9", "awready through", p_awready, 1);
    chk(pr_wvalid == 1'b1 && pr_wdata == 16'hbeef, "R9", "wdata through", pr_wdata, 16'hbeef);
    chk(p_wready == 1'b0, "R9", "wready through", p_wready, 0);
    chk(p_bvalid == 1'b1 && p_bid[0] == 2'h1, "R9", "bid through", p_bid[0], 1);
    chk(pr_bready == 1'b1, "R9", "bready through", pr_bready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    l_awvalid = '0; l_avail = '0; l_awid = '0; l_awaddr = '0; l_awlen = '0;
    l_awsize = '0; l_awburst = '0; l_wdata = '0; l_wstrb = '0; l_wlast = '0;
    l_bready = '0; r_awready = 1'b0; r_wready = 1'b1; r_bvalid = 1'b0;
    r_bid = '0; r_bresp = '0;
    l_wvalid = '1;
    p_awvalid = '0; p_avail = '0; p_awid = '0; p_awaddr = '0; p_awlen = '0;
    p_awsize = '0; p_awburst = '0; p_wvalid = '0; p_wdata = '0; p_wstrb = '0;
    p_wlast = '0; p_bready = '0; pr_awready = 1'b0; pr_wready = 1'b0;
    pr_bvalid = 1'b0; pr_bid = '0; pr_bresp = '0;
    #1;
    // R1: power-up state with data offered but nothing locked
    chk(r_awvalid == 1'b0, "R1", "awvalid at power-up", r_awvalid, 0);
    chk(l_awready == '0, "R1", "awready at power-up", l_awready, 0);
    chk(r_wvalid == 1'b0, "R1", "wvalid at power-up", r_wvalid, 0);
    chk(l_wready == '0, "R1", "wready at power-up", l_wready, 0);
    l_wvalid = '0;
    step();

    // R4, R5, R6: every port with every ID, one stalled address
    for (int p = 0; p < N; p++) begin
      for (int id = 0; id < 4; id++) begin
        single_aw(p, id, (p == 1 && id == 2) ? 3 : 0);
        drain(1'b0);
      end
    end
    // R6: two queued bursts back to back, first cycle stalled by the slave
    single_aw(0, 1, 0);
    single_aw(2, 3, 0);
    drain(1'b1);

    // R2: valid without data-available is never granted
    run_grants(3'b001, 3'b000, 8, 0, "R2");
    run_grants(3'b101, 3'b100, 12, QD, "R2");
    drain(1'b0);

    // R3, R7: all ports eligible, queue fills at ORDER_DEPTH
    run_grants(3'b111, 3'b111, 14, QD, "R7");
    drain(1'b0);
    run_grants(3'b011, 3'b111, 14, QD, "R7");
    drain(1'b1);

    b_sweep();
    pass_checks();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule